// File: doc/BRIEF.md
# Data Link Receive Byte Extractor

This block sits behind a T1 receive framer. It takes the overhead bits that carry the data link: the maintenance channel bits in extended superframe mode, or the signalling framing bits in superframe mode. They arrive one at a time with a strobe. It can drop the zeros that an HDLC-style sender inserts after a run of ones. It packs the surviving bits into bytes, first bit in the least significant position, and holds the most recent byte for the host.

Each finished byte sets a sticky byte-ready flag. It is also compared against two host-programmed patterns, and a hit sets a sticky pattern-hit flag. The host clears either flag by pulsing its clear input. Both flags feed one active-low interrupt through separate enables. This lets software ignore the link until a byte of interest turns up. Frame alignment, flag recognition and any protocol layer above the byte are handled elsewhere.

Top module: `fdl_rx_extract`

## Requirements
- R1: After reset the byte register reads 0x00, both flags read 0 and `irq_n` is 1.
- R2: Bits are packed least significant first: the first kept bit of a byte ends up in bit 0 of `rx_byte`, and the eighth kept bit ends up in bit 7.
- R3: On the clock edge that takes the eighth kept bit, `rx_byte` loads the completed byte and `full_flag` becomes 1. Both are visible in the cycle after that edge.
- R4: A cycle with `bit_vld` low changes neither the byte being assembled, nor the run of ones, nor any output.
- R5: With `destuff_en` high, a 0 that arrives after exactly five consecutive 1s is discarded and is not packed.
- R6: With `destuff_en` high, a 0 that arrives after six or more consecutive 1s is packed as an ordinary bit.
- R7: With `destuff_en` low, every valid bit is packed, whatever run of ones came before it.
- R8: When a completed byte equals `match_a` or `match_b`, `match_flag` becomes 1 on the same edge that loads the byte. A completed byte that equals neither leaves `match_flag` unchanged.
- R9: Both flags are sticky. A 1 on `clr_full` or `clr_match` clears the flag at the next edge, unless that same edge sets the flag again, in which case the set wins.
- R10: `irq_n` is 0 exactly when (`full_flag` and `full_irq_en`) or (`match_flag` and `match_irq_en`) is true.
- R11: If a new byte completes before the host has cleared the byte-ready flag, `rx_byte` is overwritten by the newer byte.
- R12: Any received 0, including a discarded one, restarts the count of consecutive ones. A second run of exactly five 1s followed by 0 therefore has its 0 dropped as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a link bit this cycle |
| bit_in | input | 1 | Received link bit |
| destuff_en | input | 1 | 1 = drop the zero that follows exactly five ones |
| match_a | input | 8 | First pattern byte |
| match_b | input | 8 | Second pattern byte |
| full_irq_en | input | 1 | Lets the byte-ready flag drive the interrupt |
| match_irq_en | input | 1 | Lets the pattern-hit flag drive the interrupt |
| clr_full | input | 1 | Write-one pulse that clears the byte-ready flag |
| clr_match | input | 1 | Write-one pulse that clears the pattern-hit flag |
| rx_byte | output | 8 | Most recently completed byte |
| full_flag | output | 1 | Sticky byte-ready flag |
| match_flag | output | 1 | Sticky pattern-hit flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The pattern-hit property compares the new byte with the pattern values sampled one cycle before the flag rises. It therefore assumes the patterns are stable over the edge that completes a byte. The bench changes them only between steps, and the reference model reads them at the same edge as the design. The properties also assume that every input changes away from the rising edge, so the bench drives all inputs one time unit after that edge. The random phase biases the stream toward ones, which produces many runs of five, six and more, and mixes in idle cycles and clear pulses, including clears that land on a completing edge.

// File: rtl/fdl_rx_pkg.sv
package fdl_rx_pkg;

    // Flag pair held by the status stage
    typedef struct packed {
        logic full;
        logic match;
    } fdl_flags_t;

    // Number of comparison patterns handled by the status stage
    localparam int unsigned FDL_NPAT = 2;

endpackage

// File: rtl/fdl_zero_drop.sv
module fdl_zero_drop #(
    parameter int unsigned RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic din,
    input  logic en,
    output logic keep,
    output logic kbit
);
    localparam int unsigned SAT = RUN + 1;
    localparam int unsigned CW  = $clog2(SAT + 1);

    typedef struct packed {
        logic [CW-1:0] ones;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        keep = 1'b0;
        kbit = din;
        if (vld) begin
            if (din) begin
                keep = 1'b1;
                if (st_q.ones != CW'(SAT)) begin
                    st_d.ones = st_q.ones + 1'b1;
                end
            end else begin
                keep      = !(en && (st_q.ones == CW'(RUN)));
                st_d.ones = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fdl_byte_pack.sv
module fdl_byte_pack #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         din,
    output logic         done,
    output logic [W-1:0] word
);
    localparam int unsigned NW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [NW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        word = {din, st_q.sh[W-1:1]};
        if (push) begin
            st_d.sh = word;
            if (st_q.cnt == NW'(W - 1)) begin
                done       = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fdl_rx_status.sv
module fdl_rx_status
    import fdl_rx_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned NPAT = FDL_NPAT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    done,
    input  logic [W-1:0]            word,
    input  logic [NPAT-1:0][W-1:0]  pats,
    input  logic                    clr_full,
    input  logic                    clr_match,
    input  logic                    en_full,
    input  logic                    en_match,
    output logic [W-1:0]            byte_q,
    output fdl_flags_t              flags,
    output logic                    irq_n
);
    typedef struct packed {
        logic [W-1:0] data;
        fdl_flags_t   fl;
    } st_t;

    st_t             st_d, st_q;
    logic [NPAT-1:0] hit;

    for (genvar p = 0; p < NPAT; p++) begin : g_cmp
        assign hit[p] = (word == pats[p]);
    end

    always_comb begin
        st_d = st_q;
        if (clr_full) begin
            st_d.fl.full = 1'b0;
        end
        if (clr_match) begin
            st_d.fl.match = 1'b0;
        end
        if (done) begin
            st_d.data    = word;
            st_d.fl.full = 1'b1;
            if (|hit) begin
                st_d.fl.match = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_q = st_q.data;
    assign flags  = st_q.fl;
    assign irq_n  = ~((st_q.fl.full & en_full) | (st_q.fl.match & en_match));

endmodule

// File: rtl/fdl_rx_extract.sv
module fdl_rx_extract
    import fdl_rx_pkg::*;
#(
    parameter int unsigned W   = 8,
    parameter int unsigned RUN = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_vld,
    input  logic         bit_in,
    input  logic         destuff_en,
    input  logic [W-1:0] match_a,
    input  logic [W-1:0] match_b,
    input  logic         full_irq_en,
    input  logic         match_irq_en,
    input  logic         clr_full,
    input  logic         clr_match,
    output logic [W-1:0] rx_byte,
    output logic         full_flag,
    output logic         match_flag,
    output logic         irq_n
);
    logic                       keep;
    logic                       kbit;
    logic                       done;
    logic [W-1:0]               word;
    logic [FDL_NPAT-1:0][W-1:0] pats;
    fdl_flags_t                 flags;

    assign pats = {match_b, match_a};

    fdl_zero_drop #(.RUN(RUN)) u_drop (
        .clk  (clk),
        .rst_n(rst_n),
        .vld  (bit_vld),
        .din  (bit_in),
        .en   (destuff_en),
        .keep (keep),
        .kbit (kbit)
    );

    fdl_byte_pack #(.W(W)) u_pack (
        .clk  (clk),
        .rst_n(rst_n),
        .push (keep),
        .din  (kbit),
        .done (done),
        .word (word)
    );

    fdl_rx_status #(.W(W), .NPAT(FDL_NPAT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .word     (word),
        .pats     (pats),
        .clr_full (clr_full),
        .clr_match(clr_match),
        .en_full  (full_irq_en),
        .en_match (match_irq_en),
        .byte_q   (rx_byte),
        .flags    (flags),
        .irq_n    (irq_n)
    );

    assign full_flag  = flags.full;
    assign match_flag = flags.match;

endmodule

// File: rtl/fdl_rx_chk.sv
module fdl_rx_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bit_vld,
    input logic [W-1:0] match_a,
    input logic [W-1:0] match_b,
    input logic         full_irq_en,
    input logic         match_irq_en,
    input logic         clr_full,
    input logic         clr_match,
    input logic [W-1:0] rx_byte,
    input logic         full_flag,
    input logic         match_flag,
    input logic         irq_n
);
    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !((full_flag && full_irq_en) || (match_flag && match_irq_en)));

    // R3
    byte_load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> full_flag);

    // R4
    idle_holds_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(rx_byte));

    // R4
    idle_no_new_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !$rose(full_flag));

    // R9
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag && !clr_full) |=> full_flag);

    // R9
    match_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !clr_match) |=> match_flag);

    // R8
    match_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> (rx_byte == $past(match_a) || rx_byte == $past(match_b)));

endmodule

bind fdl_rx_extract fdl_rx_chk #(.W(W)) u_chk (.*);

// File: tb/sim_fdl_rx_extract.sv
module sim_fdl_rx_extract;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_vld, bit_in, destuff_en;
    logic [7:0] match_a, match_b;
    logic       full_irq_en, match_irq_en, clr_full, clr_match;
    logic [7:0] rx_byte;
    logic       full_flag, match_flag, irq_n;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    // reference model state
    int       m_ones;
    logic [7:0] m_sh, m_byte;
    int       m_cnt;
    logic     m_full, m_match;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdl_rx_extract u0 (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .destuff_en(destuff_en), .match_a(match_a), .match_b(match_b),
        .full_irq_en(full_irq_en), .match_irq_en(match_irq_en),
        .clr_full(clr_full), .clr_match(clr_match), .rx_byte(rx_byte),
        .full_flag(full_flag), .match_flag(match_flag), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_irq_n();
        return !((m_full && full_irq_en) || (m_match && match_irq_en));
    endfunction

    task automatic model(input logic v, input logic b, input logic cf, input logic cm);
        logic keep, setf, setm;
        keep = 1'b1; setf = 1'b0; setm = 1'b0;
        if (v) begin
            if (b) begin
                if (m_ones < 6) m_ones++;
            end else begin
                if (destuff_en && m_ones == 5) keep = 1'b0;
                m_ones = 0;
            end
            if (keep) begin
                m_sh = {b, m_sh[7:1]};
                if (m_cnt == 7) begin
                    m_byte = m_sh; setf = 1'b1; m_full = 1'b1;
                    if (m_sh == match_a || m_sh == match_b) begin
                        setm = 1'b1; m_match = 1'b1;
                    end
                    m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
        end
        if (cf && !setf) m_full = 1'b0;
        if (cm && !setm) m_match = 1'b0;
    endtask

    task automatic step(input logic v, input logic b, input logic cf, input logic cm);
        @(negedge clk);
        bit_vld = v; bit_in = b; clr_full = cf; clr_match = cm;
        model(v, b, cf, cm);
        @(posedge clk);
        #1;
        bit_vld = 1'b0; clr_full = 1'b0; clr_match = 1'b0;
    endtask

    task automatic cmp_all(input string tag);
        chk({tag, " byte"},  rx_byte, m_byte);
        chk({tag, " full"},  {7'd0, full_flag}, {7'd0, m_full});
        chk({tag, " match"}, {7'd0, match_flag}, {7'd0, m_match});
        chk({tag, " irq"},   {7'd0, irq_n}, {7'd0, exp_irq_n()});
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) step(1'b1, v[i], 1'b0, 1'b0);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_vld = 1'b0; bit_in = 1'b0; clr_full = 1'b0; clr_match = 1'b0;
        m_ones = 0; m_sh = '0; m_byte = '0; m_cnt = 0; m_full = 1'b0; m_match = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        destuff_en = 1'b0; match_a = 8'hE7; match_b = 8'hE7;
        full_irq_en = 1'b1; match_irq_en = 1'b1;
        do_reset();

        // R1
        chk("R1 byte", rx_byte, 8'h00);
        chk("R1 flags", {6'd0, full_flag, match_flag}, 8'h00);
        chk("R1 irq", {7'd0, irq_n}, 8'h01);

        // R2, R3
        send_byte(8'hA5);
        chk("R2 lsb-first byte", rx_byte, 8'hA5);
        chk("R3 full set", {7'd0, full_flag}, 8'h01);

        // R4: partial byte, idle cycles with bit_in wiggling, then finish
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0, 1'b0); step(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, i[0], 1'b0, 1'b0);
        chk("R4 idle keeps full clear", {7'd0, full_flag}, 8'h00);
        chk("R4 idle keeps byte", rx_byte, 8'hA5);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R4 idle bits ignored", rx_byte, 8'h05);

        // R9: sticky, clear, set beats clear
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 sticky", {7'd0, full_flag}, 8'h01);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R9 cleared", {7'd0, full_flag}, 8'h00);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R9 set wins", {7'd0, full_flag}, 8'h01);
        chk("R9 byte", rx_byte, 8'h80);

        // R11
        send_byte(8'h12);
        send_byte(8'h34);
        chk("R11 overwrite", rx_byte, 8'h34);

        // R5: with destuffing, 11111 0 0 0 1 -> 0x9F
        do_reset();
        destuff_en = 1'b1;
        send_ones(5);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 drop pending", {7'd0, full_flag}, 8'h00);
        step(1'b1, 1'b0, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0, 1'b0); step(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R5 zero dropped", rx_byte, 8'h9F);

        // R7: same stream without destuffing -> 0x1F
        do_reset();
        destuff_en = 1'b0;
        send_ones(5);
        step(1'b1, 1'b0, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 zero kept", rx_byte, 8'h1F);

        // R6: six ones then 0 then 1 -> 0xBF
        do_reset();
        destuff_en = 1'b1;
        send_ones(6);
        step(1'b1, 1'b0, 1'b0, 1'b0); step(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R6 zero after six kept", rx_byte, 8'hBF);

        // R12: 11111 0 11111 0 000000 -> 0xFF then 0x03
        do_reset();
        send_ones(5); step(1'b1, 1'b0, 1'b0, 1'b0);
        send_ones(5); step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R12 first byte", rx_byte, 8'hFF);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R12 second drop", rx_byte, 8'h03);

        // R8, R10
        do_reset();
        destuff_en = 1'b0; match_a = 8'h3C; match_b = 8'h55;
        full_irq_en = 1'b0; match_irq_en = 1'b0;
        send_byte(8'h3C);
        chk("R8 hit first pattern", {7'd0, match_flag}, 8'h01);
        chk("R10 masked irq", {7'd0, irq_n}, 8'h01);
        match_irq_en = 1'b1; #1;
        chk("R10 match irq", {7'd0, irq_n}, 8'h00);
        step(1'b0, 1'b0, 1'b1, 1'b1);
        send_byte(8'h66);
        chk("R8 miss leaves clear", {7'd0, match_flag}, 8'h00);
        chk("R10 full masked", {7'd0, irq_n}, 8'h01);
        full_irq_en = 1'b1; #1;
        chk("R10 full irq", {7'd0, irq_n}, 8'h00);
        send_byte(8'h55);
        chk("R8 hit second pattern", {7'd0, match_flag}, 8'h01);
        send_byte(8'h66);
        chk("R8 miss keeps sticky", {7'd0, match_flag}, 8'h01);

        // random phase, compared against the model every step
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) begin
                destuff_en   = $urandom % 2;
                match_a      = ($urandom % 2) ? 8'hFF : 8'($urandom);
                match_b      = 8'($urandom);
                full_irq_en  = $urandom % 2;
                match_irq_en = $urandom % 2;
            end
            step(($urandom % 4) != 0, ($urandom % 3) != 0,
                 ($urandom % 16) == 0, ($urandom % 16) == 0);
            cmp_all("R2 R5 R6 random");
        end

        finish_run();
    end

endmodule